// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block is the digital mode controller of a synchronous step-down converter. It runs on a fast system clock and gets a one-cycle `cyc_tick` at the start of every switching period. Analog comparators report their results to it as level flags. From these inputs it chooses between fixed-frequency PWM and an automatic pulse-skipping mode for light load. It drives the high-side and low-side gate enables, a discharge switch, the enable of the switching-clock gate, and a mode indicator.

In PWM the high side turns on at each tick and turns off on the peak-current comparator. The low side then conducts until the next tick, so the inductor current may go negative. Two per-cycle observations are latched during each PWM period and judged at its closing tick. Both are cleared on every tick and while the controller is outside PWM. The first is whether the current crossed zero. After `ZC_RUN` such periods in a row, and only while `force_pwm` is low, the block enters skip mode. A single miss restarts that count. The second is whether the valley current fell below the negative limit. After `NEG_RUN` such periods in a row, both switches open and the discharge switch pulls the output down until the over-voltage flag clears. Switching then restarts in skip mode, and PWM stays locked out for `DWELL_CYC` system-clock cycles.

The states are PWM_OFF (reset, both switches off), PWM_HS, PWM_LS, SKIP_IDLE (both off, clock gated), SKIP_ARM (clock running, waiting for a tick), SKIP_HS, SKIP_LS and DISCHARGE. The transitions are:
- tick: PWM_OFF→PWM_HS and PWM_LS→PWM_HS. A tick in PWM_HS keeps the high side on.
- peak: PWM_HS→PWM_LS.
- negative run: PWM→DISCHARGE.
- zero-cross run: PWM→SKIP_IDLE.
- below nominal: SKIP_IDLE→SKIP_ARM.
- tick: SKIP_ARM→SKIP_HS.
- over-voltage or skip peak: SKIP_HS→SKIP_LS.
- zero cross: SKIP_LS→SKIP_IDLE.
- leave skip: any skip state→PWM_LS.
- release: DISCHARGE→SKIP_IDLE.

Top module: `pss_skip_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to PWM_OFF. In PWM_OFF `hs_en`, `ls_en`, `dis_en` and `skip_mode` are 0, `clk_en` is 1, and both run counters are cleared.
- R2: In PWM, `hs_en` is 1 from the edge that samples `cyc_tick` until the edge that samples `pk_trip`, and `ls_en` is 1 from then until the next tick. A tick while `hs_en` is 1 keeps `hs_en` at 1.
- R3: While `force_pwm` is 1, the zero-cross run never moves the block into skip mode.
- R4: When the tick closes the `ZC_RUN`th consecutive PWM period (default 8) in which `zc_det` was seen, the block enters SKIP_IDLE. There `skip_mode`=1, `hs_en`=`ls_en`=0 and `clk_en`=0.
- R5: A PWM period without `zc_det` restarts the zero-cross run from zero.
- R6: During the counting periods, `ls_en` stays 1 while `zc_det` is high, up to the next tick.
- R7: In skip mode, `below_nom` raises `clk_en`. The next tick starts a pulse with `hs_en`=1. `ov_hi` or `skip_pk` ends it with `ls_en`=1, and `zc_det` then returns the block to SKIP_IDLE with both switches off and `clk_en`=0.
- R8: Once no dwell is pending, `below_lo` or `force_pwm` moves a skip state to PWM_LS at the next edge, with `skip_mode`=0 and `ls_en`=1.
- R9: When the tick closes the `NEG_RUN`th consecutive PWM period (default 4) with `neg_trip` seen, the block enters DISCHARGE. There `dis_en`=1 and both switches are off, until an edge sees `ov_hi` low, which moves it to SKIP_IDLE. This trip wins over a zero-cross run that completes on the same tick.
- R10: After DISCHARGE ends, skip mode holds for exactly `DWELL_CYC` system-clock edges even while `below_lo` or `force_pwm` is 1. The following edge may leave skip mode.
- R11: `hs_en` and `ls_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One-cycle pulse at the start of each switching period |
| force_pwm | input | 1 | Mode pin: 1 holds fixed-frequency PWM, 0 allows pulse skipping |
| zc_det | input | 1 | Inductor current at or below zero |
| ov_hi | input | 1 | Output above nominal +1.5% |
| below_nom | input | 1 | Output below nominal |
| below_lo | input | 1 | Output below nominal −1.5% |
| pk_trip | input | 1 | PWM peak-current comparator tripped |
| skip_pk | input | 1 | Skip peak-current limit reached |
| neg_trip | input | 1 | Valley current below the negative limit |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| dis_en | output | 1 | Output discharge switch enable |
| clk_en | output | 1 | Switching-clock gate enable |
| skip_mode | output | 1 | 1 in skip states, 0 in PWM and discharge |

## Verification
The zero-cross run and the negative-current run are judged on the same tick, so both can complete in the same cycle. The bench provokes this with eight PWM periods that all show a zero crossing, the last four of which also show a negative valley. It confirms that neither action happens one tick early. It then confirms that the closing tick lands in discharge rather than skip mode, and it times the dwell that follows to the exact edge.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_PWM_OFF   = 3'd0,
        ST_PWM_HS    = 3'd1,
        ST_PWM_LS    = 3'd2,
        ST_SKIP_IDLE = 3'd3,
        ST_SKIP_ARM  = 3'd4,
        ST_SKIP_HS   = 3'd5,
        ST_SKIP_LS   = 3'd6,
        ST_DISCHARGE = 3'd7
    } pss_state_e;

    localparam int FLAG_ZC  = 0;
    localparam int FLAG_NEG = 1;
    localparam int NFLAGS   = 2;

endpackage

// File: rtl/pss_cycle_latch.sv
module pss_cycle_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] flag,
    output logic [N-1:0] seen
);
    logic [N-1:0] held;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign seen[g] = held[g] | flag[g];
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                held[g] <= 1'b0;
            end else begin
                held[g] <= seen[g];
            end
        end
    end
endmodule

// File: rtl/pss_run_count.sv
module pss_run_count #(
    parameter int RUN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic qual,
    output logic hit
);
    localparam int CW = (RUN < 2) ? 1 : $clog2(RUN);
    localparam logic [CW-1:0] LAST = CW'(RUN - 1);

    logic [CW-1:0] cnt;

    assign hit = step && qual && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            if (qual && !hit) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/pss_dwell_timer.sv
module pss_dwell_timer #(
    parameter int CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int DW = $clog2(CYC + 1);
    localparam logic [DW-1:0] START = DW'(CYC);

    logic [DW-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= START;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pss_skip_ctrl.sv
module pss_skip_ctrl
    import pss_pkg::*;
#(
    parameter int ZC_RUN    = 8,
    parameter int NEG_RUN   = 4,
    parameter int DWELL_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_tick,
    input  logic force_pwm,
    input  logic zc_det,
    input  logic ov_hi,
    input  logic below_nom,
    input  logic below_lo,
    input  logic pk_trip,
    input  logic skip_pk,
    input  logic neg_trip,
    output logic hs_en,
    output logic ls_en,
    output logic dis_en,
    output logic clk_en,
    output logic skip_mode
);
    pss_state_e state, nxt;

    logic             in_pwm;
    logic             in_skip;
    logic [NFLAGS-1:0] seen;
    logic             zc_hit;
    logic             neg_hit;
    logic             dwell_busy;
    logic             dwell_load;
    logic             leave_skip;
    logic             step_pwm;

    assign in_pwm   = (state == ST_PWM_HS) || (state == ST_PWM_LS);
    assign in_skip  = (state == ST_SKIP_IDLE) || (state == ST_SKIP_ARM) ||
                      (state == ST_SKIP_HS)   || (state == ST_SKIP_LS);
    assign step_pwm = cyc_tick && in_pwm;

    pss_cycle_latch #(.N(NFLAGS)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cyc_tick || !in_pwm),
        .flag  ({neg_trip, zc_det}),
        .seen  (seen)
    );

    pss_run_count #(.RUN(ZC_RUN)) u_zc_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_pwm),
        .step  (step_pwm),
        .qual  (seen[FLAG_ZC] && !force_pwm),
        .hit   (zc_hit)
    );

    pss_run_count #(.RUN(NEG_RUN)) u_neg_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_pwm),
        .step  (step_pwm),
        .qual  (seen[FLAG_NEG]),
        .hit   (neg_hit)
    );

    assign dwell_load = (state == ST_DISCHARGE) && !ov_hi;

    pss_dwell_timer #(.CYC(DWELL_CYC)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dwell_load),
        .busy  (dwell_busy)
    );

    assign leave_skip = !dwell_busy && (force_pwm || below_lo);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWM_OFF: begin
                if (cyc_tick) nxt = ST_PWM_HS;
            end
            ST_PWM_HS, ST_PWM_LS: begin
                if (cyc_tick) begin
                    if (neg_hit)     nxt = ST_DISCHARGE;
                    else if (zc_hit) nxt = ST_SKIP_IDLE;
                    else             nxt = ST_PWM_HS;
                end else if (state == ST_PWM_HS && pk_trip) begin
                    nxt = ST_PWM_LS;
                end
            end
            ST_SKIP_IDLE: begin
                if (leave_skip)     nxt = ST_PWM_LS;
                else if (below_nom) nxt = ST_SKIP_ARM;
            end
            ST_SKIP_ARM: begin
                if (leave_skip)    nxt = ST_PWM_LS;
                else if (cyc_tick) nxt = ST_SKIP_HS;
            end
            ST_SKIP_HS: begin
                if (leave_skip)             nxt = ST_PWM_LS;
                else if (ov_hi || skip_pk)  nxt = ST_SKIP_LS;
            end
            ST_SKIP_LS: begin
                if (leave_skip)  nxt = ST_PWM_LS;
                else if (zc_det) nxt = ST_SKIP_IDLE;
            end
            ST_DISCHARGE: begin
                if (!ov_hi) nxt = ST_SKIP_IDLE;
            end
            default: nxt = ST_PWM_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PWM_OFF;
        end else begin
            state <= nxt;
        end
    end

    // outputs
    always_comb begin
        hs_en     = 1'b0;
        ls_en     = 1'b0;
        dis_en    = 1'b0;
        clk_en    = 1'b1;
        skip_mode = in_skip;
        unique case (state)
            ST_PWM_OFF:   ;
            ST_PWM_HS:    hs_en  = 1'b1;
            ST_PWM_LS:    ls_en  = 1'b1;
            ST_SKIP_IDLE: clk_en = 1'b0;
            ST_SKIP_ARM:  ;
            ST_SKIP_HS:   hs_en  = 1'b1;
            ST_SKIP_LS:   ls_en  = 1'b1;
            ST_DISCHARGE: dis_en = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/pss_skip_ctrl_chk.sv
module pss_skip_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_tick,
    input logic force_pwm,
    input logic hs_en,
    input logic ls_en,
    input logic dis_en,
    input logic clk_en,
    input logic skip_mode
);
    // R11
    hs_ls_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R9
    dis_switch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_en |-> (!hs_en && !ls_en));

    // R9
    dis_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_en) |-> $past(cyc_tick));

    // R2
    hs_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(cyc_tick));

    // R7
    gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!hs_en && !ls_en && !dis_en));

    // R3
    no_forced_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(skip_mode) && !$past(dis_en)) |-> !$past(force_pwm));
endmodule

bind pss_skip_ctrl pss_skip_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_tick  (cyc_tick),
    .force_pwm (force_pwm),
    .hs_en     (hs_en),
    .ls_en     (ls_en),
    .dis_en    (dis_en),
    .clk_en    (clk_en),
    .skip_mode (skip_mode)
);

// File: tb/test_pss_skip_ctrl.sv
module test_pss_skip_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DWELL      = 300;

    logic clk = 1'b0;
    logic rst_n, cyc_tick, force_pwm, zc_det, ov_hi, below_nom, below_lo;
    logic pk_trip, skip_pk, neg_trip;
    logic hs_en, ls_en, dis_en, clk_en, skip_mode;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pss_skip_ctrl #(.ZC_RUN(8), .NEG_RUN(4), .DWELL_CYC(DWELL)) i_pss_skip_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .force_pwm(force_pwm),
        .zc_det(zc_det), .ov_hi(ov_hi), .below_nom(below_nom), .below_lo(below_lo),
        .pk_trip(pk_trip), .skip_pk(skip_pk), .neg_trip(neg_trip),
        .hs_en(hs_en), .ls_en(ls_en), .dis_en(dis_en), .clk_en(clk_en),
        .skip_mode(skip_mode)
    );

    function automatic int both_on(input logic a, input logic b);
        return (a && b) ? 1 : 0;
    endfunction

    function automatic int dis_conflict(input logic d, input logic h, input logic l);
        return (d && (h || l)) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cyc_tick = 0; force_pwm = 0; zc_det = 0; ov_hi = 0; below_nom = 0;
        below_lo = 0; pk_trip = 0; skip_pk = 0; neg_trip = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
        step();
    endtask

    task automatic end_tick();
        cyc_tick = 1;
        step();
        cyc_tick = 0;
    endtask

    // one PWM period: tick, peak trip, then the flags in the low-side phase
    task automatic pwm_period(input logic zc, input logic neg);
        end_tick();
        pk_trip = 1;
        step();
        pk_trip = 0;
        zc_det = zc;
        neg_trip = neg;
        step();
        if (zc) chk("R6 low side held through zero cross", ls_en, 1);
        zc_det = 0;
        neg_trip = 0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 hs_en", hs_en, 0);
        chk("R1 ls_en", ls_en, 0);
        chk("R1 dis_en", dis_en, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 skip_mode", skip_mode, 0);

        // R2 PWM period and 100% duty
        end_tick();
        chk("R2 hs on at tick", hs_en, 1);
        step();
        step();
        chk("R2 hs held without peak", hs_en, 1);
        end_tick();
        chk("R2 hs held across tick", hs_en, 1);
        pk_trip = 1;
        step();
        pk_trip = 0;
        chk("R2 hs off after peak", hs_en, 0);
        chk("R2 ls on after peak", ls_en, 1);
        step();
        chk("R2 ls held to cycle end", ls_en, 1);
        end_tick();
        chk("R2 hs on at next tick", hs_en, 1);
        chk("R11 ls off at tick", ls_en, 0);

        // R3 forced PWM ignores a long zero-cross run
        do_reset();
        force_pwm = 1;
        for (int i = 0; i < 10; i++) pwm_period(1, 0);
        end_tick();
        chk("R3 no skip under force", skip_mode, 0);
        force_pwm = 0;

        // R5 miss clears, R4 entry on the 8th consecutive
        do_reset();
        for (int i = 0; i < 7; i++) pwm_period(1, 0);
        pwm_period(0, 0);
        for (int i = 0; i < 8; i++) pwm_period(1, 0);
        chk("R5 run restarted after miss", skip_mode, 0);
        end_tick();
        chk("R4 skip entered", skip_mode, 1);
        chk("R4 hs off", hs_en, 0);
        chk("R4 ls off", ls_en, 0);
        chk("R4 clock gated", clk_en, 0);

        // R7 skip pulse sequence
        step();
        step();
        chk("R7 idle gated", clk_en, 0);
        below_nom = 1;
        step();
        below_nom = 0;
        chk("R7 clock ungated", clk_en, 1);
        chk("R7 no pulse before tick", hs_en, 0);
        step();
        step();
        chk("R7 waits for tick", hs_en, 0);
        end_tick();
        chk("R7 pulse starts", hs_en, 1);
        skip_pk = 1;
        step();
        skip_pk = 0;
        chk("R7 skip peak ends pulse hs", hs_en, 0);
        chk("R7 skip peak ends pulse ls", ls_en, 1);
        step();
        chk("R7 ls until zero", ls_en, 1);
        zc_det = 1;
        step();
        zc_det = 0;
        chk("R7 back to idle ls", ls_en, 0);
        chk("R7 back to idle gate", clk_en, 0);
        chk("R7 still skip", skip_mode, 1);
        below_nom = 1;
        step();
        below_nom = 0;
        end_tick();
        chk("R7 second pulse", hs_en, 1);
        ov_hi = 1;
        step();
        ov_hi = 0;
        chk("R7 over-voltage ends pulse", ls_en, 1);
        zc_det = 1;
        step();
        zc_det = 0;

        // R8 exit on deep droop
        below_lo = 1;
        step();
        below_lo = 0;
        chk("R8 left skip", skip_mode, 0);
        chk("R8 low side on", ls_en, 1);

        // R9 negative run and zero-cross run finish on the same tick
        do_reset();
        for (int i = 0; i < 4; i++) pwm_period(1, 0);
        for (int i = 0; i < 4; i++) pwm_period(1, 1);
        chk("R9 no early trip", dis_en, 0);
        chk("R9 no early skip", skip_mode, 0);
        end_tick();
        chk("R9 discharge wins", dis_en, 1);
        chk("R9 not skip", skip_mode, 0);
        chk("R9 hs off", hs_en, 0);
        chk("R9 ls off", ls_en, 0);
        ov_hi = 1;
        for (int i = 0; i < 5; i++) step();
        chk("R9 discharge held", dis_en, 1);

        // R10 dwell in skip before PWM
        ov_hi = 0;
        force_pwm = 1;
        below_lo = 1;
        step();
        chk("R9 released", dis_en, 0);
        chk("R10 skip after discharge", skip_mode, 1);
        for (int i = 0; i < DWELL; i++) step();
        chk("R10 dwell holds skip", skip_mode, 1);
        step();
        chk("R10 pwm after dwell", skip_mode, 0);
        chk("R10 ls on", ls_en, 1);
        idle_inputs();

        // R11 random stimulus
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            cyc_tick  = ($urandom % 8) == 0;
            force_pwm = ($urandom % 16) == 0;
            zc_det    = ($urandom % 3) == 0;
            ov_hi     = ($urandom % 6) == 0;
            below_nom = ($urandom % 4) == 0;
            below_lo  = ($urandom % 20) == 0;
            pk_trip   = ($urandom % 4) == 0;
            skip_pk   = ($urandom % 5) == 0;
            neg_trip  = ($urandom % 3) == 0;
            step();
            chk("R11 interlock", both_on(hs_en, ls_en), 0);
            chk("R9 discharge isolation", dis_conflict(dis_en, hs_en, ls_en), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule